// File: doc/BRIEF.md
# Gliding Stereo Delay-Line Address Generator

This block produces the write and read word addresses for a stereo echo line kept in an external memory with a 16-bit word address. Left and right samples sit in adjacent words, so each stereo frame uses two consecutive locations. A strobe pulses once per channel access and moves both pointers forward by one word. A second strobe marks the end of each frame. At that point the read pointer is placed exactly one delay behind the write pointer.

The requested delay arrives as an 8-bit coarse value that counts in units of 256 words. The block does not jump to a new request. On each frame end it moves its actual delay a short distance toward the request: four words (two frames) when the delay must grow, and two words (one frame) when it must shrink. Because the read pointer is re-anchored every frame, a growing delay replays the stored audio backwards at normal speed. A shrinking delay plays it forwards at double speed. Either way the listener hears a glide and no click. The memory bus timing and the sample data path belong to other blocks.

Top module: `stereo_glide_addr`

## Requirements
- R1: After a synchronous reset, both addresses read zero, the actual delay is zero and the registered target is zero.
- R2: Each cycle with `chan_adv` high raises `wr_addr` by exactly one word. It stays unchanged in every other cycle.
- R3: In a cycle with `chan_adv` high and `frame_end` low, `rd_addr` rises by one word. With both low it holds.
- R4: The target delay in words is the `tgt_hi` value registered one cycle earlier, multiplied by 256, with a zero low byte.
- R5: On `frame_end`, a delay below the target grows by 4 words.
- R6: On `frame_end`, a delay above the target shrinks by 2 words.
- R7: On `frame_end`, a delay equal to the target is kept unchanged.
- R8: The actual delay is always even. Its bit 0 is cleared before the comparison, so `wr_addr - rd_addr` is even after every frame end.
- R9: On `frame_end`, `rd_addr` becomes the write address after this cycle's advance minus the delay after this cycle's slew step. This holds even when `chan_adv` is high in the same cycle.
- R10: All address and delay arithmetic wraps modulo 2^16. The write pointer passes from 0xFFFF to 0x0000, and the read address wraps below zero when the delay exceeds the write address.
- R11: Between frame ends the delay does not move, even when `tgt_hi` changes. `wr_addr - rd_addr` stays constant across channel advances within a frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_adv | input | 1 | One pulse per channel access; advances both pointers |
| frame_end | input | 1 | Single-cycle strobe after both channel writes of a frame |
| tgt_hi | input | 8 | Requested delay, units of 256 words |
| wr_addr | output | 16 | Current write word address |
| rd_addr | output | 16 | Current read word address |

## Verification
Two situations are hard to reach from the ports: the write pointer wrapping past 0xFFFF, and the delay gliding near the top of the address space. Both need tens of thousands of frames. The bench drives a long upward glide to a target of 255, which takes over sixteen thousand frames. It then runs a long stretch of channel advances without frame ends so the write pointer wraps. Early in the run it also sets a target larger than the write address, so the read address has to wrap below zero. A frame shape that raises the advance strobe in the same cycle as the frame end checks the ordering in R9.

// File: rtl/sgd_pkg.sv
`timescale 1ns/1ps
package sgd_pkg;

    localparam int unsigned ADDR_W    = 16;
    localparam int unsigned TGT_W     = 8;
    localparam int unsigned STEP_UP   = 4;
    localparam int unsigned STEP_DOWN = 2;

    typedef enum logic [1:0] {
        SLEW_HOLD = 2'd0,
        SLEW_UP   = 2'd1,
        SLEW_DOWN = 2'd2
    } slew_e;

    typedef struct packed {
        logic adv;
        logic tick;
    } sgd_ev_t;

    // Direction the delay must move to approach the goal.
    function automatic slew_e slew_decide(input logic [31:0] cur, input logic [31:0] goal);
        if (cur < goal)
            return SLEW_UP;
        else if (cur > goal)
            return SLEW_DOWN;
        else
            return SLEW_HOLD;
    endfunction

    // Clear bit 0 so the delay always spans whole stereo frames.
    function automatic logic [31:0] frame_align(input logic [31:0] v);
        return {v[31:1], 1'b0};
    endfunction

endpackage

// File: rtl/sgd_wrap_ctr.sv
`timescale 1ns/1ps
module sgd_wrap_ctr #(
    parameter int unsigned W = sgd_pkg::ADDR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);

    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        if (load)
            q_next = load_val;
        else if (inc)
            q_next = q + ONE;
        else
            q_next = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_next;
    end

    p_step_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (inc && !load) |=> (q == W'($past(q) + ONE)));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!inc && !load) |=> $stable(q));

endmodule

// File: rtl/sgd_slew.sv
`timescale 1ns/1ps
module sgd_slew
    import sgd_pkg::*;
#(
    parameter int unsigned AW   = sgd_pkg::ADDR_W,
    parameter int unsigned TW   = sgd_pkg::TGT_W,
    parameter int unsigned UP   = sgd_pkg::STEP_UP,
    parameter int unsigned DOWN = sgd_pkg::STEP_DOWN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [TW-1:0] tgt_hi,
    output logic [AW-1:0] act_q,
    output logic [AW-1:0] act_d
);

    localparam int unsigned LOW_W = AW - TW;
    localparam logic [AW-1:0] UP_W = AW'(UP);
    localparam logic [AW-1:0] DN_W = AW'(DOWN);

    logic [TW-1:0] des_q;
    logic [AW-1:0] goal;
    logic [AW-1:0] act_even;
    slew_e         dir;

    generate
        if (LOW_W > 0) begin : g_scaled
            assign goal = {des_q, {LOW_W{1'b0}}};
        end else begin : g_direct
            assign goal = AW'(des_q);
        end
    endgenerate

    always_comb begin
        act_even = AW'(frame_align(32'(act_q)));
        dir      = slew_decide(32'(act_even), 32'(goal));
        act_d    = act_q;
        if (tick) begin
            unique case (dir)
                SLEW_UP:   act_d = act_even + UP_W;
                SLEW_DOWN: act_d = act_even - DN_W;
                default:   act_d = act_even;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            des_q <= '0;
            act_q <= '0;
        end else begin
            des_q <= tgt_hi;
            act_q <= act_d;
        end
    end

    p_even_delay_r8: assert property (@(posedge clk) disable iff (rst)
        act_q[0] == 1'b0);

    p_grow_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && act_q < goal) |=> (act_q == AW'($past(act_q) + UP_W)));

    p_shrink_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && act_q > goal) |=> (act_q == AW'($past(act_q) - DN_W)));

    p_settled_r7: assert property (@(posedge clk) disable iff (rst)
        (tick && act_q == goal) |=> $stable(act_q));

    p_frame_only_r11: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_q));

endmodule

// File: rtl/sgd_align.sv
`timescale 1ns/1ps
module sgd_align #(
    parameter int unsigned AW = sgd_pkg::ADDR_W
) (
    input  logic [AW-1:0] wr_next,
    input  logic [AW-1:0] delay_next,
    output logic [AW-1:0] rd_anchor
);

    always_comb rd_anchor = wr_next - delay_next;

endmodule

// File: rtl/stereo_glide_addr.sv
`timescale 1ns/1ps
module stereo_glide_addr
    import sgd_pkg::*;
#(
    parameter int unsigned AW   = sgd_pkg::ADDR_W,
    parameter int unsigned TW   = sgd_pkg::TGT_W,
    parameter int unsigned UP   = sgd_pkg::STEP_UP,
    parameter int unsigned DOWN = sgd_pkg::STEP_DOWN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          chan_adv,
    input  logic          frame_end,
    input  logic [TW-1:0] tgt_hi,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);

    sgd_ev_t       ev;
    logic [AW-1:0] wr_next;
    logic [AW-1:0] rd_next;
    logic [AW-1:0] dly_q;
    logic [AW-1:0] dly_next;
    logic [AW-1:0] anchor;

    always_comb begin
        ev.adv  = chan_adv;
        ev.tick = frame_end;
    end

    sgd_wrap_ctr #(.W(AW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .inc      (ev.adv),
        .load     (1'b0),
        .load_val ('0),
        .q        (wr_addr),
        .q_next   (wr_next)
    );

    sgd_slew #(.AW(AW), .TW(TW), .UP(UP), .DOWN(DOWN)) u_slew (
        .clk    (clk),
        .rst    (rst),
        .tick   (ev.tick),
        .tgt_hi (tgt_hi),
        .act_q  (dly_q),
        .act_d  (dly_next)
    );

    sgd_align #(.AW(AW)) u_align (
        .wr_next    (wr_next),
        .delay_next (dly_next),
        .rd_anchor  (anchor)
    );

    sgd_wrap_ctr #(.W(AW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .inc      (ev.adv),
        .load     (ev.tick),
        .load_val (anchor),
        .q        (rd_addr),
        .q_next   (rd_next)
    );

    p_wr_step_r2: assert property (@(posedge clk) disable iff (rst)
        chan_adv |=> (wr_addr == AW'($past(wr_addr) + AW'(1))));

    p_rd_step_r3: assert property (@(posedge clk) disable iff (rst)
        (chan_adv && !frame_end) |=> (rd_addr == AW'($past(rd_addr) + AW'(1))));

    p_anchor_r9: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (AW'(wr_addr - rd_addr) == dly_q));

    p_gap_steady_r11: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> (AW'(wr_addr - rd_addr) == AW'($past(wr_addr) - $past(rd_addr))));

    p_reset_zero_r1: assert property (@(posedge clk)
        $past(rst) |-> (wr_addr == '0 && rd_addr == '0));

endmodule

// File: tb/tb_stereo_glide_addr.sv
`timescale 1ns/1ps
module tb_stereo_glide_addr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        chan_adv = 1'b0;
    logic        frame_end = 1'b0;
    logic [7:0]  tgt_hi = 8'd0;
    logic [15:0] wr_addr;
    logic [15:0] rd_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] m_wr, m_rd, m_act;
    logic [7:0]  m_des;
    string       last_dir;

    stereo_glide_addr dut (
        .clk(clk), .rst(rst), .chan_adv(chan_adv), .frame_end(frame_end),
        .tgt_hi(tgt_hi), .wr_addr(wr_addr), .rd_addr(rd_addr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge.
    task automatic cyc(input bit adv, input bit fe, input logic [7:0] tgt);
        logic [15:0] goal;
        logic [15:0] wr_n;
        string       wtag;
        chan_adv  = adv;
        frame_end = fe;
        tgt_hi    = tgt;
        @(posedge clk);
        goal = {m_des, 8'h00};
        wr_n = m_wr + 16'(adv);
        if (fe) begin
            if (m_act < goal) begin
                m_act = m_act + 16'd4; last_dir = "R5";
            end else if (m_act > goal) begin
                m_act = m_act - 16'd2; last_dir = "R6";
            end else begin
                last_dir = "R7";
            end
            m_rd = wr_n - m_act;
        end else begin
            m_rd = m_rd + 16'(adv);
        end
        m_des = tgt;
        wtag  = (adv && wr_n == 16'h0000) ? "R10 write wrap" : "R2 write step";
        m_wr  = wr_n;
        @(negedge clk);
        chk(wtag, wr_addr, m_wr);
        chk(fe ? last_dir : "R3 read step", rd_addr, m_rd);
    endtask

    // A frame: two channel advances then the frame-end strobe.
    // With merged set, the second advance shares the frame-end cycle.
    task automatic frame(input logic [7:0] tgt, input bit merged);
        if (merged) begin
            cyc(1, 0, tgt);
            cyc(1, 1, tgt);
        end else begin
            cyc(1, 0, tgt);
            cyc(1, 0, tgt);
            cyc(0, 1, tgt);
        end
        chk("R9 read anchored", rd_addr, wr_addr - m_act);
        chk("R8 even delay", {15'd0, 1'(wr_addr - rd_addr)}, 16'd0);
        if (m_wr < m_act)
            chk("R10 read wraps below zero", rd_addr, 16'(32'h10000 + m_wr - m_act));
    endtask

    initial begin
        m_wr = 0; m_rd = 0; m_act = 0; m_des = 0; last_dir = "";
        repeat (3) @(negedge clk);
        // reset held with strobes active must still give zero
        chan_adv = 1'b1; frame_end = 1'b1; tgt_hi = 8'h33;
        @(negedge clk);
        rst = 1'b0; chan_adv = 1'b0; frame_end = 1'b0; tgt_hi = 8'h00;
        chk("R1 reset write", wr_addr, 16'h0000);
        chk("R1 reset read", rd_addr, 16'h0000);

        // glide up to 512 words from a small write address (read wraps low)
        for (int i = 0; i < 130; i++) frame(8'd2, i[0]);
        chk("R4 target 2 reached", wr_addr - rd_addr, 16'd512);
        for (int i = 0; i < 8; i++) frame(8'd2, 1'b0);
        chk("R7 hold at target", wr_addr - rd_addr, 16'd512);

        // glide down to 256
        for (int i = 0; i < 130; i++) frame(8'd1, i[1]);
        chk("R4 target 1 reached", wr_addr - rd_addr, 16'd256);

        // target changes inside a frame must not move the gap
        cyc(1, 0, 8'd9);
        cyc(1, 0, 8'd0);
        cyc(1, 0, 8'd200);
        chk("R11 gap fixed mid-frame", wr_addr - rd_addr, 16'd256);
        cyc(0, 0, 8'd1);
        chk("R11 gap fixed idle", wr_addr - rd_addr, 16'd256);
        frame(8'd1, 1'b0);
        chk("R7 equal stays", wr_addr - rd_addr, 16'd256);

        // long upward glide to the top target
        for (int i = 0; i < 16300; i++) frame(8'd255, 1'b0);
        chk("R4 target 255 reached", wr_addr - rd_addr, 16'hFF00);

        // plain advances until the write pointer wraps past 0xFFFF
        for (int i = 0; i < 40000; i++) cyc(1, 0, 8'd255);
        frame(8'd255, 1'b1);
        chk("R11 gap after long run", wr_addr - rd_addr, 16'hFF00);

        // shrink slightly
        for (int i = 0; i < 130; i++) frame(8'd254, 1'b0);
        chk("R4 target 254 reached", wr_addr - rd_addr, 16'hFE00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(190000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule